// File: doc/BRIEF.md
# Frequency Offset Compensation Loop

This block sits beside the loop filter of a digital clock-recovery loop and removes a slowly varying frequency offset from the phase path. It splits time into fixed windows of 512 system clock cycles. In each window it keeps the net count of phase-correction pulses from the loop filter, with each lead pulse adding one and each lag pulse taking one away. When a window closes, that net count is added to a saturating running total. The total is the block's estimate of the frequency offset, expressed in phase steps per window.

During the following window the block sends that many single-step pulses back to the phase control. The pulses point in the direction of the estimate's sign and are spread as evenly as the slot grid allows. A divide-by-four prescaler gives 128 pulse slots per window. A binary rate multiplier maps each bit of the estimate's magnitude onto one class of slots. The estimate moves only by each window's residual, so a triangular frequency sweep is followed in small increments while the main loop keeps a narrow bandwidth.

Top module: `freq_comp_loop`

## Requirements
- R1: A synchronous active-high reset clears the window position, the window count and the running total to zero. Both compensation outputs stay low while reset is held. The first window after reset emits no pulses, whatever total was held before.
- R2: A window is 512 cycles long, and its first cycle is the first cycle after reset is released. Within a window, a cycle with only lead_in high adds one to the count, a cycle with only lag_in high subtracts one, and a cycle with both high or both low leaves the count unchanged.
- R3: The window count is an 8-bit signed value that saturates at +127 and -127 instead of wrapping.
- R4: In the last cycle of each window, the count including that cycle's input is added to the running total, and the count restarts at zero. The total is 8-bit signed and saturates at +127 and -128. At any other time it holds its value.
- R5: In the window that follows an update, the number of compensation pulses equals the magnitude of the total, capped at 127. A positive total drives comp_lead, a negative total drives comp_lag, and a zero total drives neither.
- R6: Slot s (0 to 127) is evaluated at window position 4*s, and its pulse is registered, so it appears at position 4*s+1. Every pulse is one cycle wide, and comp_lead and comp_lag are never high in the same cycle.
- R7: Slot s fires when magnitude bit 6-j is set, where j is the count of trailing zeros of s (s > 0). Slot 0 never fires. So a magnitude of 1 gives a single pulse at window position 257, and a magnitude of 127 gives its first pulse at position 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lead_in | input | 1 | Lead correction pulse from the loop filter |
| lag_in | input | 1 | Lag correction pulse from the loop filter |
| comp_lead | output | 1 | Compensation pulse that advances the phase one step |
| comp_lag | output | 1 | Compensation pulse that retards the phase one step |

## Verification
Pulses driven in window w affect only the total that takes effect at the first cycle of window w+1. So every count is checked in the window after its stimulus, once the whole 512-cycle window has been observed. Inside a window, a slot decided at position 4*s shows at the port one register later, at position 4*s+1. The bench therefore logs each pulse against a window position that it counts itself from reset release. It checks the exact landing positions for magnitudes 1 and 127, and it checks that every pulse sits on that phase. Outputs are read at the falling edge, half a cycle after the edge that produced them.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_LEAD = 2'b01,
      STEP_LAG  = 2'b10
   } step_e;

   // Net direction of one cycle of loop-filter pulses; both at once cancel.
   function automatic step_e step_of(input logic up, input logic dn);
      step_e s;
      if (up && !dn)
         s = STEP_LEAD;
      else if (dn && !up)
         s = STEP_LAG;
      else
         s = STEP_NONE;
      return s;
   endfunction

endpackage

// File: rtl/fcl_window_timer.sv
module fcl_window_timer #(
   parameter int WIN_LOG2 = 9,
   parameter int PRE_LOG2 = 2,
   localparam int SLOT_W  = WIN_LOG2 - PRE_LOG2
) (
   input  logic                clk,
   input  logic                rst,
   output logic [WIN_LOG2-1:0] win_pos,
   output logic                win_last,
   output logic                slot_strobe,
   output logic [SLOT_W-1:0]   slot_idx
);

   always_ff @(posedge clk) begin
      if (rst)
         win_pos <= '0;
      else
         win_pos <= win_pos + {{(WIN_LOG2-1){1'b0}}, 1'b1};
   end

   assign win_last = &win_pos;
   assign slot_idx = win_pos[WIN_LOG2-1:PRE_LOG2];

   generate
      if (PRE_LOG2 == 0) begin : g_no_prescale
         assign slot_strobe = 1'b1;
      end else begin : g_prescale
         assign slot_strobe = ~|win_pos[PRE_LOG2-1:0];
      end
   endgenerate

endmodule

// File: rtl/fcl_window_counter.sv
module fcl_window_counter
   import fcl_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  step_e                   step,
   input  logic                    win_last,
   output logic signed [CNT_W-1:0] win_cnt,
   output logic signed [CNT_W-1:0] cnt_upd
);

   localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
   localparam logic signed [CNT_W-1:0] CNT_MIN = -CNT_MAX;
   localparam logic signed [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

   always_comb begin
      cnt_upd = win_cnt;
      case (step)
         STEP_LEAD: if (win_cnt != CNT_MAX) cnt_upd = win_cnt + ONE;
         STEP_LAG:  if (win_cnt != CNT_MIN) cnt_upd = win_cnt - ONE;
         default:   cnt_upd = win_cnt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         win_cnt <= '0;
      else if (win_last)
         win_cnt <= '0;
      else
         win_cnt <= cnt_upd;
   end

endmodule

// File: rtl/fcl_accumulator.sv
module fcl_accumulator #(
   parameter int CNT_W = 8,
   parameter int ACC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    win_last,
   input  logic signed [CNT_W-1:0] cnt_upd,
   output logic signed [ACC_W-1:0] acc
);

   localparam int SUM_W = ACC_W + 1;
   localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'((2 ** (ACC_W-1)) - 1);
   localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_W'(2 ** (ACC_W-1));

   logic signed [SUM_W-1:0] acc_ext;
   logic signed [SUM_W-1:0] cnt_ext;
   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] acc_nx;

   assign acc_ext = {acc[ACC_W-1], acc};
   assign cnt_ext = {{(SUM_W-CNT_W){cnt_upd[CNT_W-1]}}, cnt_upd};
   assign sum     = acc_ext + cnt_ext;

   always_comb begin
      if (sum > SUM_HI)
         acc_nx = {1'b0, {(ACC_W-1){1'b1}}};
      else if (sum < SUM_LO)
         acc_nx = {1'b1, {(ACC_W-1){1'b0}}};
      else
         acc_nx = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else if (win_last)
         acc <= acc_nx;
   end

endmodule

// File: rtl/fcl_rate_mult.sv
module fcl_rate_mult #(
   parameter int ACC_W   = 8,
   parameter int SLOT_W  = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [ACC_W-1:0] acc,
   input  logic                    slot_strobe,
   input  logic [SLOT_W-1:0]       slot_idx,
   output logic                    comp_lead,
   output logic                    comp_lag
);

   localparam int MAG_W = SLOT_W;
   localparam logic [ACC_W:0] ABS_ONE = {{ACC_W{1'b0}}, 1'b1};

   logic [ACC_W:0]     abs_w;
   logic [MAG_W-1:0]   mag;
   logic [MAG_W-1:0]   mag_rev;
   logic [SLOT_W-1:0]  tz_hot;
   logic               fire;
   logic               fire_lead;
   logic               fire_lag;

   assign abs_w = acc[ACC_W-1] ? (~{acc[ACC_W-1], acc}) + ABS_ONE
                               : {1'b0, acc};

   // Cap the magnitude at the number of usable slots.
   generate
      if (MAG_W > ACC_W) begin : g_mag_wide
         assign mag = MAG_W'(abs_w);
      end else begin : g_mag_cap
         localparam logic [ACC_W:0] MAG_CAP = (ACC_W+1)'((2 ** MAG_W) - 1);
         assign mag = (abs_w > MAG_CAP) ? {MAG_W{1'b1}} : MAG_W'(abs_w);
      end
   endgenerate

   // One-hot of the trailing-zero position of the slot index.
   genvar j;
   generate
      for (j = 0; j < SLOT_W; j++) begin : g_slot_class
         if (j == 0) begin : g_lsb
            assign tz_hot[j] = slot_idx[0];
         end else begin : g_upper
            assign tz_hot[j] = slot_idx[j] & ~|slot_idx[j-1:0];
         end
         assign mag_rev[j] = mag[MAG_W-1-j];
      end
   endgenerate

   assign fire      = slot_strobe & |(tz_hot & mag_rev);
   assign fire_lead = fire & ~acc[ACC_W-1];
   assign fire_lag  = fire &  acc[ACC_W-1];

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               comp_lead <= 1'b0;
               comp_lag  <= 1'b0;
            end else begin
               comp_lead <= fire_lead;
               comp_lag  <= fire_lag;
            end
         end
      end else begin : g_out_comb
         assign comp_lead = fire_lead & ~rst;
         assign comp_lag  = fire_lag  & ~rst;
      end
   endgenerate

endmodule

// File: rtl/freq_comp_loop.sv
module freq_comp_loop
   import fcl_pkg::*;
#(
   parameter int WIN_LOG2 = 9,
   parameter int PRE_LOG2 = 2,
   parameter int CNT_W    = 8,
   parameter int ACC_W    = 8,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic lead_in,
   input  logic lag_in,
   output logic comp_lead,
   output logic comp_lag
);

   localparam int SLOT_W = WIN_LOG2 - PRE_LOG2;

   generate
      if (PRE_LOG2 < 1 || PRE_LOG2 >= WIN_LOG2) begin : g_bad_pre
         $error("freq_comp_loop: PRE_LOG2 must lie in 1 .. WIN_LOG2-1");
      end
      if (CNT_W < 2 || CNT_W > ACC_W) begin : g_bad_cnt
         $error("freq_comp_loop: CNT_W must lie in 2 .. ACC_W");
      end
      if (SLOT_W < 2) begin : g_bad_slot
         $error("freq_comp_loop: at least two slot bits are needed");
      end
   endgenerate

   logic [WIN_LOG2-1:0]     win_pos;
   logic                    win_last;
   logic                    slot_strobe;
   logic [SLOT_W-1:0]       slot_idx;
   logic signed [CNT_W-1:0] win_cnt;
   logic signed [CNT_W-1:0] cnt_upd;
   logic signed [ACC_W-1:0] acc;
   step_e                   step;

   assign step = step_of(lead_in, lag_in);

   fcl_window_timer #(
      .WIN_LOG2 (WIN_LOG2),
      .PRE_LOG2 (PRE_LOG2)
   ) u_timer (
      .clk         (clk),
      .rst         (rst),
      .win_pos     (win_pos),
      .win_last    (win_last),
      .slot_strobe (slot_strobe),
      .slot_idx    (slot_idx)
   );

   fcl_window_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst      (rst),
      .step     (step),
      .win_last (win_last),
      .win_cnt  (win_cnt),
      .cnt_upd  (cnt_upd)
   );

   fcl_accumulator #(
      .CNT_W (CNT_W),
      .ACC_W (ACC_W)
   ) u_accum (
      .clk      (clk),
      .rst      (rst),
      .win_last (win_last),
      .cnt_upd  (cnt_upd),
      .acc      (acc)
   );

   fcl_rate_mult #(
      .ACC_W   (ACC_W),
      .SLOT_W  (SLOT_W),
      .OUT_REG (OUT_REG)
   ) u_gen (
      .clk         (clk),
      .rst         (rst),
      .acc         (acc),
      .slot_strobe (slot_strobe),
      .slot_idx    (slot_idx),
      .comp_lead   (comp_lead),
      .comp_lag    (comp_lag)
   );

endmodule

// File: rtl/freq_comp_loop_chk.sv
module freq_comp_loop_chk #(
   parameter int WIN_LOG2 = 9,
   parameter int PRE_LOG2 = 2,
   parameter int CNT_W    = 8,
   parameter int ACC_W    = 8,
   parameter bit OUT_REG  = 1'b1
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    comp_lead,
   input logic                    comp_lag,
   input logic [WIN_LOG2-1:0]     win_pos,
   input logic signed [CNT_W-1:0] win_cnt,
   input logic signed [ACC_W-1:0] acc
);

   localparam logic [PRE_LOG2-1:0]     PHASE   = OUT_REG ? PRE_LOG2'(1) : '0;
   localparam logic signed [CNT_W-1:0] CNT_BAD = {1'b1, {(CNT_W-1){1'b0}}};

   // R1: state is clear in the first cycle after reset is released
   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (win_pos == '0 && win_cnt == '0 && acc == '0 && !comp_lead && !comp_lag));

   // R2: the count restarts after the last cycle of a window
   a_r2_cnt_clear: assert property (@(posedge clk) disable iff (rst)
      (&win_pos) |=> (win_cnt == '0));

   // R3: the symmetric saturation never reaches the most negative code
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      win_cnt != CNT_BAD);

   // R4: the running total changes only at a window boundary
   a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
      !(&win_pos) |=> $stable(acc));

   // R6: never both directions at once
   a_r6_excl: assert property (@(posedge clk) disable iff (rst)
      !(comp_lead && comp_lag));

   // R6: pulses are one cycle wide
   a_r6_lead_gap: assert property (@(posedge clk) disable iff (rst)
      comp_lead |=> !comp_lead);
   a_r6_lag_gap: assert property (@(posedge clk) disable iff (rst)
      comp_lag |=> !comp_lag);

   // R6: pulses land on the slot phase
   a_r6_slot_phase: assert property (@(posedge clk) disable iff (rst)
      (comp_lead || comp_lag) |-> (win_pos[PRE_LOG2-1:0] == PHASE));

endmodule

bind freq_comp_loop freq_comp_loop_chk #(
   .WIN_LOG2 (WIN_LOG2),
   .PRE_LOG2 (PRE_LOG2),
   .CNT_W    (CNT_W),
   .ACC_W    (ACC_W),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .comp_lead (comp_lead),
   .comp_lag  (comp_lag),
   .win_pos   (win_pos),
   .win_cnt   (win_cnt),
   .acc       (acc)
);

// File: tb/freq_comp_loop_tb.sv
`timescale 1ns/1ps
module freq_comp_loop_tb;

   localparam int WIN    = 512;
   localparam int NWIN   = 32;
   localparam int WD_CYC = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic lead_in = 1'b0;
   logic lag_in  = 1'b0;
   logic comp_lead;
   logic comp_lag;

   int checks = 0;
   int errors = 0;
   int bcyc;

   int n_lead [NWIN];
   int n_lag  [NWIN];
   int first_pos [NWIN];
   int exp_n  [NWIN];
   bit exp_up [NWIN];
   int both_seen;
   int off_phase;
   int min_gap;
   int last_cyc;
   int acc_m;
   int wi;

   always #2 clk = ~clk;

   freq_comp_loop u_dut (
      .clk       (clk),
      .rst       (rst),
      .lead_in   (lead_in),
      .lag_in    (lag_in),
      .comp_lead (comp_lead),
      .comp_lag  (comp_lag)
   );

   // Window position counted from reset release (R2).
   always_ff @(posedge clk) begin
      if (rst) bcyc <= 0;
      else     bcyc <= bcyc + 1;
   end

   always @(negedge clk) begin
      if (!rst) begin
         int w;
         w = bcyc / WIN;
         if (w < NWIN) begin
            if (comp_lead) n_lead[w]++;
            if (comp_lag)  n_lag[w]++;
            if ((comp_lead || comp_lag) && first_pos[w] < 0)
               first_pos[w] = bcyc % WIN;
         end
         if (comp_lead && comp_lag) both_seen++;
         if (comp_lead || comp_lag) begin
            if (bcyc % 4 != 1) off_phase++;
            if (last_cyc >= 0 && bcyc - last_cyc < min_gap) min_gap = bcyc - last_cyc;
            last_cyc = bcyc;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      for (int k = 0; k < NWIN; k++) begin
         n_lead[k] = 0; n_lag[k] = 0; first_pos[k] = -1;
         exp_n[k] = 0; exp_up[k] = 1'b1;
      end
      both_seen = 0; off_phase = 0; min_gap = 1000000; last_cyc = -1;
      acc_m = 0; wi = 0;
   endtask

   // Drives one full window, checks what that window emitted, updates the model.
   task automatic run_window(input int nlead, input int nlag, input int nboth, input string req);
      int c;
      c = 0;
      while (bcyc % WIN != 0) @(negedge clk);
      for (int i = 0; i < WIN; i++) begin
         logic l, g;
         l = (i < nlead) || (i < nboth);
         g = (i >= 256 && i - 256 < nlag) || (i < nboth);
         lead_in = l;
         lag_in  = g;
         if (l && !g && c < 127)  c++;
         if (g && !l && c > -127) c--;
         @(negedge clk);
      end
      lead_in = 1'b0;
      lag_in  = 1'b0;
      chk(req, $sformatf("lead pulses in window %0d", wi), n_lead[wi], exp_up[wi] ? exp_n[wi] : 0);
      chk(req, $sformatf("lag pulses in window %0d", wi),  n_lag[wi],  exp_up[wi] ? 0 : exp_n[wi]);
      acc_m = acc_m + c;
      if (acc_m > 127)  acc_m = 127;
      if (acc_m < -128) acc_m = -128;
      exp_up[wi+1] = (acc_m >= 0);
      exp_n[wi+1]  = (acc_m < 0) ? ((-acc_m > 127) ? 127 : -acc_m) : acc_m;
      wi++;
   endtask

   task automatic t_basic();
      run_window(20, 5, 0, "R1");   // first window after reset emits nothing
      run_window(0, 0, 0, "R5");    // 15 lead
      run_window(0, 10, 0, "R5");   // 15 lead
      run_window(0, 30, 0, "R2");   // 5 lead, lag pulses lowered the total
   endtask

   task automatic t_counter_sat();
      run_window(200, 0, 0, "R5");  // 25 lag
      run_window(100, 0, 0, "R3");  // 102 lead: count clamped at 127
   endtask

   task automatic t_acc_sat();
      run_window(0, 200, 0, "R4");  // 127 lead: total clamped at +127
      chk("R7", "first pulse position, magnitude 127", first_pos[wi-1], 5);
   endtask

   task automatic t_cancel();
      run_window(0, 0, 256, "R5");  // zero total, no pulses
      run_window(1, 0, 0, "R2");    // simultaneous pulses cancelled
   endtask

   task automatic t_spacing();
      run_window(0, 200, 0, "R7");  // single lead pulse
      chk("R7", "position of single pulse", first_pos[wi-1], 257);
   endtask

   task automatic t_neg_clamp();
      run_window(0, 200, 0, "R5");  // 126 lag
      run_window(0, 0, 0, "R4");    // total -128 gives 127 lag
      chk("R7", "first lag pulse position, magnitude 127", first_pos[wi-1], 5);
   endtask

   task automatic t_pulse_shape();
      chk("R6", "cycles with both outputs high", both_seen, 0);
      chk("R6", "pulses off the slot phase", off_phase, 0);
      chk("R6", "minimum spacing below 4", (min_gap < 4) ? 1 : 0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1", "comp_lead during reset", int'(comp_lead), 0);
         chk("R1", "comp_lag during reset",  int'(comp_lag),  0);
      end
      clear_log();
      rst = 1'b0;
      run_window(30, 0, 0, "R1");   // old -128 total must be gone
      run_window(0, 0, 0, "R5");    // 30 lead
   endtask

   initial begin
      clear_log();
      repeat (5) @(negedge clk);
      chk("R1", "comp_lead in reset", int'(comp_lead), 0);
      chk("R1", "comp_lag in reset",  int'(comp_lag),  0);
      rst = 1'b0;
      t_basic();
      t_counter_sat();
      t_acc_sat();
      t_cancel();
      t_spacing();
      t_neg_clamp();
      t_pulse_shape();
      t_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule